// File: doc/BRIEF.md
# Hibernation Countdown Timer

A 16-bit one-shot down-counter for low-power wake-up timing, placed on a simple register bus. Software starts it by writing a nonzero start value to the load register. The counter then steps down on a slow 32.768 kHz tick-enable input. There is no separate run bit. Writing zero to the load register halts the timer and clears the count. To resume later, software writes the saved count back as a new load value.

A control bit chooses between two resolutions. In the fine resolution the counter moves once per tick. In the coarse resolution it moves once every 4096 ticks, which is 125 ms per step. When the count goes from one to zero, the block sets a sticky event flag and the counter rests at zero. The event flag drives a maskable interrupt line. Software clears the flag by writing one to it.

Top module: `hib_timer`

## Requirements
- R1: After synchronous reset, COUNT reads 0, the event flag reads 0, the control register reads 0 and `irq` is low.
- R2: A bus write to address 0 with a nonzero low half loads COUNT with `bus_wdata[15:0]` on the next cycle and starts the countdown. Such a write takes priority over a tick in the same cycle.
- R3: A bus write of zero to address 0 forces COUNT to 0. The timer then stays at 0 under any number of ticks and raises no event.
- R4: With control bit 0 clear (fine resolution), COUNT decreases by exactly one on each cycle where `tick` is high, and holds on cycles where it is low.
- R5: With control bit 0 set (coarse resolution), COUNT decreases once per 4096 ticks. Every write to address 0 restarts this 4096-tick period from its beginning.
- R6: When COUNT steps from 1 to 0, the event flag (bit 0 of address 3) becomes 1. COUNT then stays at 0 until address 0 is written again.
- R7: Writing 1 to bit 0 of address 3 clears the event flag. If an event occurs in the same cycle as this clear, the flag stays set.
- R8: `irq` is high exactly when the event flag is set and control bit 1 (interrupt enable) is set.
- R9: Address 2 returns COUNT. Bus writes to address 2 leave COUNT unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable from the 32.768 kHz time base |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 load, 1 control, 2 count, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register, zero-extended |
| irq | output | 1 | Masked terminal-count interrupt |

## Verification
Two situations are the hardest to create from the ports.

The first is a status clear and a terminal-count event landing in the same cycle. The stimulus sets the flag with a first countdown and reloads a count of one. It then drives the status-clear write and a tick in the same cycle, and reads the flag afterwards.

The second is the prescaler restart in coarse mode. The stimulus runs 4000 ticks, rewrites the load register, and then samples COUNT after tick 4095 and after tick 4096. This shows that a full 4096-tick period followed the rewrite.

// File: rtl/hib_timer_pkg.sv
package hib_timer_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LOAD  = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_STAT  = 2'd3
    } reg_sel_e;

    // control register image: bit 1 interrupt enable, bit 0 coarse resolution
    typedef struct packed {
        logic irq_en;
        logic coarse;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic wr;
        reg_sel_e sel;
    } bus_cmd_t;

    function automatic logic cmd_hits(input bus_cmd_t cmd, input reg_sel_e which);
        return cmd.wr && (cmd.sel == which);
    endfunction

endpackage

// File: rtl/hib_prescale.sv
module hib_prescale #(
    parameter int PRE_W = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic restart,
    input  logic active,
    input  logic coarse,
    output logic step
);
    generate
        if (PRE_W == 0) begin : g_nodiv
            assign step = tick && active;
        end else begin : g_div
            logic [PRE_W-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    div_q <= '0;
                end else if (tick && active && coarse) begin
                    div_q <= div_q + 1'b1;
                end
            end
            assign step = tick && active && (!coarse || (&div_q));
        end
    endgenerate
endmodule

// File: rtl/hib_counter.sv
module hib_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             active,
    output logic             evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step && active) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign active = (cnt_q != '0);
    assign evt    = step && !load && (cnt_q == ONE);
    assign count  = cnt_q;
endmodule

// File: rtl/hib_regs.sv
module hib_regs
    import hib_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              evt,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output ctrl_t             ctrl,
    output logic              flag,
    output logic [DATA_W-1:0] bus_rdata
);
    bus_cmd_t cmd;
    logic [CNT_W-1:0] last_load_q;
    ctrl_t ctrl_q;
    logic flag_q;
    logic clr_req;

    assign cmd      = '{wr: bus_wr, sel: reg_sel_e'(bus_addr)};
    assign load     = cmd_hits(cmd, SEL_LOAD);
    assign load_val = bus_wdata[CNT_W-1:0];
    assign clr_req  = cmd_hits(cmd, SEL_STAT) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            last_load_q <= '0;
            ctrl_q      <= '0;
            flag_q      <= 1'b0;
        end else begin
            if (load) last_load_q <= load_val;
            if (cmd_hits(cmd, SEL_CTRL)) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (evt) flag_q <= 1'b1;
            else if (clr_req) flag_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_LOAD:  bus_rdata = DATA_W'(last_load_q);
            SEL_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            SEL_COUNT: bus_rdata = DATA_W'(count);
            SEL_STAT:  bus_rdata = DATA_W'(flag_q);
            default:   bus_rdata = '0;
        endcase
    end

    assign ctrl = ctrl_q;
    assign flag = flag_q;
endmodule

// File: rtl/hib_timer.sv
module hib_timer
    import hib_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic             load;
    logic [CNT_W-1:0] load_val;
    ctrl_t            ctrl;
    logic             flag;
    logic             step;
    logic             active;
    logic             evt;
    logic [CNT_W-1:0] count;

    hib_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .count(count), .evt(evt), .load(load),
        .load_val(load_val), .ctrl(ctrl), .flag(flag), .bus_rdata(bus_rdata)
    );

    hib_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .tick(tick), .restart(load),
        .active(active), .coarse(ctrl.coarse), .step(step)
    );

    hib_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .step(step), .count(count), .active(active), .evt(evt)
    );

    assign irq = flag && ctrl.irq_en;
endmodule

// File: rtl/hib_timer_chk.sv
module hib_timer_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  count,
    input logic              flag,
    input logic              ien,
    input logic              coarse,
    input logic              irq
);
    logic ld;
    assign ld = bus_wr && (bus_addr == 2'd0);

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        ld |=> count == $past(bus_wdata[CNT_W-1:0]));

    p_hold_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (!ld && count == '0) |=> count == '0);

    p_fine_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!ld && tick && !coarse && count != '0) |=> count == CNT_W'($past(count) - 1'b1));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!ld && !tick) |=> $stable(count));

    p_event_r6: assert property (@(posedge clk) disable iff (rst)
        (!ld && tick && !coarse && count == CNT_W'(1)) |=> flag);

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd3 && bus_wdata[0] && !tick) |=> !flag);

    p_mask_r8: assert property (@(posedge clk) disable iff (rst)
        !ien |-> !irq);

    p_raise_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && ien) |-> irq);
endmodule

bind hib_timer hib_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .count(count), .flag(flag), .ien(ctrl.irq_en),
    .coarse(ctrl.coarse), .irq(irq)
);

// File: tb/sim_hib_timer.sv
module sim_hib_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hib_timer u0 (
        .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] load;
        logic [15:0] ticks;
        logic [15:0] exp_cnt;
        logic        exp_flag;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'd5,      16'd3,  16'd2,      1'b0},
        '{16'd5,      16'd5,  16'd0,      1'b1},
        '{16'd1,      16'd1,  16'd0,      1'b1},
        '{16'd300,    16'd7,  16'd293,    1'b0},
        '{16'd3,      16'd10, 16'd0,      1'b1},
        '{16'hFFFF,   16'd2,  16'hFFFD,   1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd2, v); chk("R1 count", v, 0);
        rd(2'd3, v); chk("R1 flag", v, 0);
        rd(2'd1, v); chk("R1 ctrl", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 R4 R6 vector table, fine resolution
        for (int i = 0; i < NV; i++) begin
            wr(2'd3, 32'd1);
            wr(2'd0, {16'd0, VECS[i].load});
            ticks(int'(VECS[i].ticks));
            rd(2'd2, v); chk("R4 vec count", v, {16'd0, VECS[i].exp_cnt});
            rd(2'd3, v); chk("R6 vec flag", v, {31'd0, VECS[i].exp_flag});
        end

        // R2 load only, no tick
        wr(2'd3, 32'd1);
        wr(2'd0, 32'h0001_0009);
        rd(2'd2, v); chk("R2 load", v, 9);
        repeat (4) @(negedge clk);
        rd(2'd2, v); chk("R4 hold without tick", v, 9);

        // R2 load wins over same-cycle tick
        tick = 1'b1; wr(2'd0, 32'd20); tick = 1'b0;
        rd(2'd2, v); chk("R2 load beats tick", v, 20);

        // R3 zero write halts and clears
        ticks(3);
        wr(2'd0, 32'd0);
        rd(2'd2, v); chk("R3 zero write", v, 0);
        ticks(25);
        rd(2'd2, v); chk("R3 stays zero", v, 0);
        rd(2'd3, v); chk("R3 no event", v, 0);

        // R3 restart from new value
        wr(2'd0, 32'd10); ticks(2);
        wr(2'd0, 32'd0); wr(2'd0, 32'd4); ticks(1);
        rd(2'd2, v); chk("R3 restart", v, 3);

        // R9 count read-only
        wr(2'd2, 32'h55);
        rd(2'd2, v); chk("R9 write ignored", v, 3);

        // R8 interrupt masking
        wr(2'd0, 32'd1); ticks(1);
        chk("R8 masked irq", {31'd0, irq}, 0);
        wr(2'd1, 32'd2);
        #1; chk("R8 irq enabled", {31'd0, irq}, 1);
        wr(2'd3, 32'd1);
        #1; chk("R7 clear", {31'd0, irq}, 0);
        rd(2'd3, v); chk("R7 flag cleared", v, 0);

        // R7 event wins over same-cycle clear
        wr(2'd0, 32'd1); ticks(1);
        rd(2'd3, v); chk("R6 flag set", v, 1);
        wr(2'd0, 32'd1);
        tick = 1'b1; wr(2'd3, 32'd1); tick = 1'b0;
        rd(2'd3, v); chk("R7 event beats clear", v, 1);
        rd(2'd2, v); chk("R6 rests at zero", v, 0);
        wr(2'd3, 32'd1);

        // R5 coarse resolution and prescaler restart
        wr(2'd1, 32'd1);
        wr(2'd0, 32'd2);
        ticks(4000);
        rd(2'd2, v); chk("R5 no early step", v, 2);
        wr(2'd0, 32'd2);
        ticks(4095);
        rd(2'd2, v); chk("R5 prescaler restarted", v, 2);
        ticks(1);
        rd(2'd2, v); chk("R5 coarse step", v, 1);
        ticks(4096);
        rd(2'd2, v); chk("R5 second step", v, 0);
        rd(2'd3, v); chk("R6 coarse event", v, 1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule